// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software run one clause-22 management transaction at a time to an external PHY. Everything goes through a single 32-bit register. Software writes the PHY address, the register address and, for a write, the 16 data bits, and sets a read or a write request bit in the same register write. The controller then sends the 64-bit management frame on the MDC/MDIO pins. For a read it releases MDIO, gathers the sixteen bits the PHY returns and puts them into the register's upper half. It then raises a completion flag.

Software clears the flag by writing a one to it, issues a command, and polls the flag until it is set, giving up after a timeout. MDC runs only while a frame is in flight. It is made by dividing the system clock, with a high time and a low time of `CLK_HALF` system clocks each. The register reads back combinationally at all times.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 0, MDC is low, MDIO output-enable is low and the MDIO output is high.
- R2: A register write made while idle starts a transaction when bit 14 (read) or bit 13 (write) is set. If both are set the command is a read. The frame carries, in order: 32 ones, start bits 0 then 1, the opcode (0,1 for a write; 1,0 for a read), the PHY address taken from bits 4:0, the register address taken from bits 12:8, two turnaround bits, then 16 data bits. Every field is sent most significant bit first.
- R3: During a frame MDC has a period of 2*CLK_HALF system clocks. Its first rising edge comes CLK_HALF clocks after the clock edge that accepted the command. Frame bit k is presented from the falling MDC edge before it, and bit 0 is presented from the start itself. The MDIO output changes only on those edges.
- R4: For a write, the turnaround bits are 1 then 0, the data bits are the value written into bits 31:16, and output-enable stays high for all 64 bits.
- R5: For a read, output-enable is low from the first turnaround bit (frame bit 46) to the end of the frame. MDIO input is sampled on the 16 rising MDC edges of bits 48 to 63, and the result, first sample as the MSB, is placed in bits 31:16 at completion.
- R6: The frame ends at the falling MDC edge after the 64th rising edge (2*CLK_HALF*64 clocks after the start). In that same clock, bit 15 becomes 1 and bits 14:13 become 0.
- R7: Writing 1 to bit 15 while idle clears it, and writing 0 there leaves it unchanged. Starting a command also clears it.
- R8: Register writes made while a transaction is in progress have no effect. Fields, flag and frame are unchanged and no new command is started.
- R9: A write made while idle with bits 14:13 both zero updates bits 31:16, 12:8 and 4:0 and starts no frame. Bits 7:5 always read 0.
- R10: Bit 14 reads 1 while a read is in progress and bit 13 reads 1 while a write is in progress. Both read 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = controller drives) |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or divider phase shows at the pins within one MDC period. It appears as an MDC edge or an MDIO transition shifted by a system clock, or as a frame bit out of place. It also moves the completion flag away from its exact cycle, 128*CLK_HALF clocks after the start. A wrong opcode latch shows at the turnaround of the same frame, where output-enable drops or stays high on the wrong bit. Corruption of the register or a write that slips through while busy shows on the very next clock, because the register read value is compared every cycle.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam int FRAME_BITS = 64;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    // register image, bit 31 down to bit 0
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              done;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] regad;
        logic [2:0]        rsvd;
        logic [ADDR_W-1:0] phy;
    } csr_t;

    typedef struct packed {
        mdio_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic              is_rd;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        is_rd = (r.op == OP_READ);
        ta    = is_rd ? 2'b00 : 2'b10;
        d     = is_rd ? '0 : r.wdata;
        return {32'hFFFF_FFFF, 2'b01, r.op, r.phy, r.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == CNT_W'(CLK_HALF - 1));
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [FRAME_BITS-1:0] sh;
    logic [BIT_W-1:0]      bitcnt;
    logic                  is_rd;
    logic                  last_bit;

    assign last_bit = (bitcnt == BIT_W'(FRAME_BITS - 1));
    assign done_evt = busy && fall_evt && last_bit;
    assign mdio_o   = busy ? sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = busy && !(is_rd && (bitcnt >= BIT_W'(TA_FIRST)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sh      <= '0;
            bitcnt  <= '0;
            is_rd   <= 1'b0;
            rd_data <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            sh     <= build_frame(req);
            bitcnt <= '0;
            is_rd  <= (req.op == OP_READ);
        end else if (busy) begin
            if (rise_evt && is_rd && (bitcnt >= BIT_W'(DATA_FIRST)))
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (fall_evt) begin
                if (last_bit) begin
                    busy <= 1'b0;
                end else begin
                    sh     <= sh << 1;
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R3
    mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    csr_t              csr;
    csr_t              wv;
    mdio_req_t         req;
    logic              busy;
    logic              done_evt;
    logic              rise_evt;
    logic              fall_evt;
    logic              accept;
    logic              start;
    logic [DATA_W-1:0] rd_data;

    assign wv     = csr_t'(reg_wdata);
    assign accept = reg_wr && !busy;
    assign start  = accept && (wv.rd || wv.wr);

    always_comb begin
        req.op    = wv.rd ? OP_READ : OP_WRITE;
        req.phy   = wv.phy;
        req.regad = wv.regad;
        req.wdata = wv.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr <= '0;
        end else if (done_evt) begin
            csr.done <= 1'b1;
            csr.rd   <= 1'b0;
            csr.wr   <= 1'b0;
            if (csr.rd)
                csr.data <= rd_data;
        end else if (accept) begin
            csr.data  <= wv.data;
            csr.regad <= wv.regad;
            csr.phy   <= wv.phy;
            if (start) begin
                csr.rd   <= wv.rd;
                csr.wr   <= wv.wr && !wv.rd;
                csr.done <= 1'b0;
            end else if (wv.done) begin
                csr.done <= 1'b0;
            end
        end
    end

    assign reg_rdata = {csr.data, csr.done, csr.rd, csr.wr, csr.regad, 3'b000, csr.phy};

    mdio_clk_gen #(.CLK_HALF(CLK_HALF)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req      (req),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done_evt (done_evt),
        .rd_data  (rd_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // R6
    done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> csr.done);

    // R10
    cmd_bits_track_chk: assert property (@(posedge clk) disable iff (rst)
        ((csr.rd || csr.wr) == busy));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(csr)));

    // R7
    done_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !csr.done);

endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
    localparam int H   = 2;
    localparam int END = 128 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_cmd_ctrl #(.CLK_HALF(H)) u_mdio_cmd_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    finished = 0;
    bit    live = 0;
    string cur_req = "R1";
    logic [15:0] phy_val = '0;

    // behavioural reference state
    logic [15:0] m_data;
    logic [4:0]  m_phy, m_regad;
    logic        m_done, m_busy, m_rd, m_cmdr, m_cmdw;
    logic [63:0] m_frame;
    int          m_t;

    always @(posedge clk) begin
        live = 1;
        if (rst) begin
            m_data = 0; m_phy = 0; m_regad = 0; m_done = 0;
            m_busy = 0; m_rd = 0; m_cmdr = 0; m_cmdw = 0; m_t = 0; m_frame = 0;
        end else if (m_busy) begin
            m_t = m_t + 1;
            if (m_t == END) begin
                m_busy = 0; m_done = 1; m_cmdr = 0; m_cmdw = 0;
                if (m_rd) m_data = phy_val;
            end
        end else if (reg_wr) begin
            m_data  = reg_wdata[31:16];
            m_regad = reg_wdata[12:8];
            m_phy   = reg_wdata[4:0];
            if (reg_wdata[14] || reg_wdata[13]) begin
                m_rd = reg_wdata[14];
                m_cmdr = m_rd; m_cmdw = !m_rd;
                m_done = 0; m_busy = 1; m_t = 0;
                m_frame[63:32] = 32'hFFFF_FFFF;
                m_frame[31:30] = 2'b01;
                m_frame[29:28] = m_rd ? 2'b10 : 2'b01;
                m_frame[27:23] = m_phy;
                m_frame[22:18] = m_regad;
                m_frame[17:16] = m_rd ? 2'b00 : 2'b10;
                m_frame[15:0]  = m_rd ? 16'h0 : m_data;
            end else if (reg_wdata[15]) begin
                m_done = 0;
            end
        end
    end

    always @(negedge clk) begin
        int k;
        logic e_mdc, e_oe, e_o;
        logic [31:0] e_reg;
        cycles++;
        if (live && !finished) begin
            k = m_t / (2 * H);
            e_mdc = m_busy ? (((m_t / H) % 2) == 1) : 1'b0;
            e_oe  = m_busy ? !(m_rd && k >= 46) : 1'b0;
            e_o   = m_busy ? m_frame[63 - k] : 1'b1;
            e_reg = {m_data, m_done, m_cmdr, m_cmdw, m_regad, 3'b000, m_phy};
            vectors++;
            if (reg_rdata !== e_reg) begin
                miscompares++;
                $display("FAIL %s reg_rdata act=%h exp=%h at cycle %0d", cur_req, reg_rdata, e_reg, cycles);
            end
            if (mdc !== e_mdc) begin
                miscompares++;
                $display("FAIL %s mdc act=%b exp=%b at cycle %0d", cur_req, mdc, e_mdc, cycles);
            end
            if (mdio_oe !== e_oe) begin
                miscompares++;
                $display("FAIL %s mdio_oe act=%b exp=%b at cycle %0d", cur_req, mdio_oe, e_oe, cycles);
            end
            if (e_oe || !m_busy) begin
                if (mdio_o !== e_o) begin
                    miscompares++;
                    $display("FAIL %s mdio_o act=%b exp=%b bit %0d cycle %0d", cur_req, mdio_o, e_o, k, cycles);
                end
            end
            // PHY side: drive the read response for the current bit
            if (m_busy && m_rd && k >= 48) mdio_i <= phy_val[63 - k];
            else if (m_busy && m_rd && k == 47) mdio_i <= 1'b0;
            else mdio_i <= 1'b1;
        end
        if (cycles > 100000 && !finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done;
        int n = 0;
        while (reg_rdata[15] !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        vectors++;
        if (reg_rdata[15] !== 1'b1) begin
            miscompares++;
            $display("FAIL R6 completion flag act=%b exp=1", reg_rdata[15]);
        end
        idle(3);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        cur_req = "R1";  idle(3);
        cur_req = "R9";  wr(32'hABCD_1FE5); idle(3);
        cur_req = "R2";  wr(32'h5A3C_2A11); idle(20);
        cur_req = "R8";  wr(32'hFFFF_7FFF); wr(32'h0000_6000); idle(10);
        cur_req = "R4";  idle(100);
        cur_req = "R6";  wait_done;
        cur_req = "R7";  wr(32'h5A3C_0A11); idle(2); wr(32'h0000_8000); idle(2);
        cur_req = "R5";  phy_val = 16'hC3A5; wr(32'h0000_4103); wait_done;
        cur_req = "R2";  phy_val = 16'h0001; wr(32'h1234_7F1F); idle(4);
        cur_req = "R10"; wait_done;
        cur_req = "R3";  wr(32'h0000_2000); wait_done;
        cur_req = "R5";  phy_val = 16'hFFFF; wr(32'h0000_5F00); wait_done;
        cur_req = "R9";  wr(32'h8000_0000); idle(3);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule